// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block interprets write cycles sent to an 8-bit parallel NOR flash and carries out what they ask for on a small behavioural byte array. Writes arrive on a synchronous strobe interface: one cycle of `wr_en_i` carries an address and a data byte. The decoder watches the two-write unlock pattern and the command byte that follows it. It starts a single-byte program operation or a whole-array erase, and it enters or leaves a shortened bypass programming mode.

Program and erase run as timed embedded operations. `busy_o` stays high while one runs, and any write that arrives during that time is dropped. Programming can only clear bits, so the stored byte becomes the AND of the old byte and the new byte. An attempt to raise a cleared bit sets `err_o`. The accelerate input forces bypass mode while it is held. The synchronous reset `rst` is the hardware reset: it stops any embedded operation at once and returns the decoder to normal array reading.

The array is read through `rd_addr_i`/`rd_data_o` with one cycle of latency while `busy_o` is low.

Top module: `nor_cmd_decoder`

## Requirements
- R1: A standard program is four writes: AAh at address 555h, 55h at 2AAh, A0h at 555h, then the target address with its data. After `busy_o` falls, reading that address returns the programmed value. Addresses are compared on their low 11 bits.
- R2: A write that does not match the next expected step ends the sequence and returns the decoder to idle. This covers a wrong address or a wrong data byte, and the write is not acted on. A following data write then programs nothing.
- R3: The writes AAh at 555h, 55h at 2AAh, 20h at 555h put the decoder in bypass mode, and `bypass_o` reads 1.
- R4: In bypass mode a program takes two writes: A0h at any address, then the target address with its data.
- R5: In bypass mode every write other than A0h and 90h is ignored. This includes a complete chip-erase sequence. The array and the mode stay unchanged.
- R6: Bypass mode is left by 90h followed by 00h, with the address ignored on both writes. Afterwards `bypass_o` is 0 and a two-write bypass program no longer programs. If 90h is followed by any other byte, the decoder stays in bypass mode and nothing is programmed.
- R7: Chip erase is six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. It sets every byte to FFh and holds `busy_o` high for 2^ADDR_W cycles.
- R8: A program holds `busy_o` high for exactly PROG_CYC+1 cycles. Writes issued during that time have no effect on the decoder state.
- R9: Asserting `rst` clears `busy_o` on the next cycle and aborts a program in progress, leaving the target byte unchanged. The decoder returns to idle with `bypass_o`=0 and `err_o`=0.
- R10: A program stores old AND new. `err_o` rises when the operation ends if the new data has a 1 where the stored byte has a 0. `err_o` is cleared when the next program or erase starts.
- R11: While `accel_i` is high the decoder is in bypass mode one cycle later and stays there, even after a 90h/00h exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| accel_i | input | 1 | Accelerate input, forces bypass mode |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data or command byte |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data, one cycle after the address |
| busy_o | output | 1 | Embedded program or erase running |
| err_o | output | 1 | Last program tried to raise a cleared bit |
| bypass_o | output | 1 | Decoder is in bypass mode |

## Verification
The hardest case to reach is a hardware reset that lands inside the wait of a running program. A reset there must leave the byte untouched, which needs the full unlock sequence and then a reset timed a few cycles after the address write. The bench counts cycles from that write to place the reset. A related case is a stream of writes fed in while `busy_o` is high: the bench sends a complete bypass-entry sequence during the program wait and then confirms that bypass mode did not start.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] UNLOCK_ADDR_A = 11'h555;
  localparam logic [CMD_AW-1:0] UNLOCK_ADDR_B = 11'h2AA;
  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_ERS_SET  = 8'h80;
  localparam logic [7:0] CODE_ERS_CHIP = 8'h10;
  localparam logic [7:0] CODE_BYP_ON   = 8'h20;
  localparam logic [7:0] CODE_BYP_OFF1 = 8'h90;
  localparam logic [7:0] CODE_BYP_OFF2 = 8'h00;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM,
    SQ_ERS3, SQ_ERS4, SQ_ERS5,
    SQ_BIDLE, SQ_BPGM, SQ_BRST
  } seq_state_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_FETCH, ENG_HOLD, ENG_SWEEP} eng_state_t;

  function automatic logic is_bypass(seq_state_t s);
    return (s == SQ_BIDLE) || (s == SQ_BPGM) || (s == SQ_BRST);
  endfunction
endpackage

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm import nor_cmd_pkg::*; #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              busy_i,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [7:0]        start_data_o,
  output logic              bypass_o
);
  seq_state_t state_q, state_d;
  logic take, at_a, at_b;

  assign take = wr_en_i && !busy_i;
  assign at_a = (wr_addr_i[CMD_AW-1:0] == UNLOCK_ADDR_A);
  assign at_b = (wr_addr_i[CMD_AW-1:0] == UNLOCK_ADDR_B);
  assign start_addr_o = wr_addr_i;
  assign start_data_o = wr_data_i;
  assign bypass_o = is_bypass(state_q);

  always_comb begin
    state_d = state_q;
    prog_start_o = 1'b0;
    erase_start_o = 1'b0;
    if (take) begin
      case (state_q)
        SQ_IDLE: state_d = (at_a && wr_data_i == CODE_UNLOCK_A) ? SQ_UNL1 : SQ_IDLE;
        SQ_UNL1: state_d = (at_b && wr_data_i == CODE_UNLOCK_B) ? SQ_UNL2 : SQ_IDLE;
        SQ_UNL2: begin
          state_d = SQ_IDLE;
          if (at_a) begin
            if (wr_data_i == CODE_PROGRAM)      state_d = SQ_PGM;
            else if (wr_data_i == CODE_ERS_SET) state_d = SQ_ERS3;
            else if (wr_data_i == CODE_BYP_ON)  state_d = SQ_BIDLE;
          end
        end
        SQ_PGM: begin
          prog_start_o = 1'b1;
          state_d = SQ_IDLE;
        end
        SQ_ERS3: state_d = (at_a && wr_data_i == CODE_UNLOCK_A) ? SQ_ERS4 : SQ_IDLE;
        SQ_ERS4: state_d = (at_b && wr_data_i == CODE_UNLOCK_B) ? SQ_ERS5 : SQ_IDLE;
        SQ_ERS5: begin
          state_d = SQ_IDLE;
          if (at_a && wr_data_i == CODE_ERS_CHIP) erase_start_o = 1'b1;
        end
        SQ_BIDLE: begin
          if (wr_data_i == CODE_PROGRAM)       state_d = SQ_BPGM;
          else if (wr_data_i == CODE_BYP_OFF1) state_d = SQ_BRST;
        end
        SQ_BPGM: begin
          prog_start_o = 1'b1;
          state_d = SQ_BIDLE;
        end
        SQ_BRST: state_d = (wr_data_i == CODE_BYP_OFF2) ? SQ_IDLE : SQ_BIDLE;
        default: state_d = SQ_IDLE;
      endcase
    end
    if (accel_i && !is_bypass(state_d)) state_d = SQ_BIDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SQ_IDLE;
    else     state_q <= state_d;
  end

  // R8: a busy engine freezes the sequence tracker
  assert_busy_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !accel_i) |=> $stable(state_q));
  // R11: accelerate input holds bypass mode
  assert_accel_bypass_R11: assert property (@(posedge clk) disable iff (rst)
    accel_i |=> bypass_o);
  // R5: no erase can start from bypass mode
  assert_bypass_no_erase_R5: assert property (@(posedge clk) disable iff (rst)
    is_bypass(state_q) |-> !erase_start_o);
endmodule

// File: rtl/nor_embed_engine.sv
module nor_embed_engine import nor_cmd_pkg::*; #(
  parameter int ADDR_W   = 11,
  parameter int PROG_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_start_i,
  input  logic              erase_start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [7:0]        start_data_i,
  input  logic [7:0]        old_byte_i,
  output logic              busy_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] eng_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int CNT_W = $clog2(PROG_CYC + 1) + 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

  eng_state_t state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        tgt_q;
  logic              hold_done;

  assign busy_o = (state_q != ENG_IDLE);
  assign eng_addr_o = addr_q;
  assign hold_done = (state_q == ENG_HOLD) && (cnt_q == CNT_LAST);

  always_comb begin
    mem_we_o = 1'b0;
    mem_wdata_o = 8'hFF;
    if (hold_done) begin
      mem_we_o = 1'b1;
      mem_wdata_o = tgt_q & old_byte_i;
    end else if (state_q == ENG_SWEEP) begin
      mem_we_o = 1'b1;
    end
    if (rst) mem_we_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      tgt_q   <= '0;
      err_o   <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (prog_start_i) begin
            state_q <= ENG_FETCH;
            addr_q  <= start_addr_i;
            tgt_q   <= start_data_i;
            err_o   <= 1'b0;
          end else if (erase_start_i) begin
            state_q <= ENG_SWEEP;
            addr_q  <= '0;
            err_o   <= 1'b0;
          end
        end
        ENG_FETCH: begin
          state_q <= ENG_HOLD;
          cnt_q   <= '0;
        end
        ENG_HOLD: begin
          if (hold_done) begin
            state_q <= ENG_IDLE;
            err_o   <= |(tgt_q & ~old_byte_i);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ENG_SWEEP: begin
          if (addr_q == ADDR_LAST) state_q <= ENG_IDLE;
          else addr_q <= addr_q + 1'b1;
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // R8: operations are only launched into an idle engine
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (prog_start_i || erase_start_i) |-> !busy_o);
  // R10: error flag clears when a program begins
  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (prog_start_i && !busy_o) |=> !err_o);
  // R9: hardware reset ends any operation
  assert_reset_abort_R9: assert property (@(posedge clk)
    rst |=> (!busy_o && !err_o));
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
  parameter int ADDR_W   = 11,
  parameter int PROG_CYC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              bypass_o
);
  logic              prog_start, erase_start;
  logic [ADDR_W-1:0] start_addr, eng_addr, ram_raddr;
  logic [7:0]        start_data, mem_wdata;
  logic              mem_we;

  nor_seq_fsm #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .accel_i(accel_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .busy_i(busy_o),
    .prog_start_o(prog_start), .erase_start_o(erase_start),
    .start_addr_o(start_addr), .start_data_o(start_data),
    .bypass_o(bypass_o)
  );

  nor_embed_engine #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_eng (
    .clk(clk), .rst(rst),
    .prog_start_i(prog_start), .erase_start_i(erase_start),
    .start_addr_i(start_addr), .start_data_i(start_data),
    .old_byte_i(rd_data_o),
    .busy_o(busy_o), .err_o(err_o),
    .eng_addr_o(eng_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  assign ram_raddr = busy_o ? eng_addr : rd_addr_i;

  nor_byte_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(eng_addr), .wdata(mem_wdata),
    .raddr(ram_raddr), .rdata(rd_data_o)
  );
endmodule

// File: tb/tb_nor_cmd_decoder.sv
module tb_nor_cmd_decoder;
  localparam int ADDR_W = 11;
  localparam int PROG_CYC = 8;
  localparam int NV = 64;
  localparam logic [1:0] W = 2'd0, RDV = 2'd1, BYP = 2'd2, ERF = 2'd3;

  // vector: {op, requirement number, address, data or expected value}
  localparam logic [24:0] VECS [NV] = '{
    // R7 chip erase
    {W,4'd7,11'h555,8'hAA}, {W,4'd7,11'h2AA,8'h55}, {W,4'd7,11'h555,8'h80},
    {W,4'd7,11'h555,8'hAA}, {W,4'd7,11'h2AA,8'h55}, {W,4'd7,11'h555,8'h10},
    {RDV,4'd7,11'h000,8'hFF},
    // R1 standard program
    {W,4'd1,11'h555,8'hAA}, {W,4'd1,11'h2AA,8'h55}, {W,4'd1,11'h555,8'hA0},
    {W,4'd1,11'h123,8'h3C}, {RDV,4'd1,11'h123,8'h3C},
    // R10 AND programming and error flag
    {ERF,4'd10,11'h000,8'h00},
    {W,4'd10,11'h555,8'hAA}, {W,4'd10,11'h2AA,8'h55}, {W,4'd10,11'h555,8'hA0},
    {W,4'd10,11'h123,8'h0F}, {RDV,4'd10,11'h123,8'h0C}, {ERF,4'd10,11'h000,8'h01},
    // R2 broken sequences
    {W,4'd2,11'h555,8'hAA}, {W,4'd2,11'h2AA,8'h55}, {W,4'd2,11'h556,8'hA0},
    {W,4'd2,11'h200,8'h00}, {RDV,4'd2,11'h200,8'hFF},
    {W,4'd2,11'h555,8'hAA}, {W,4'd2,11'h2AA,8'h11}, {W,4'd2,11'h555,8'hA0},
    {W,4'd2,11'h201,8'h00}, {RDV,4'd2,11'h201,8'hFF},
    // R10 error cleared by next program
    {W,4'd10,11'h555,8'hAA}, {W,4'd10,11'h2AA,8'h55}, {W,4'd10,11'h555,8'hA0},
    {W,4'd10,11'h300,8'hF0}, {ERF,4'd10,11'h000,8'h00},
    // R3 bypass entry
    {W,4'd3,11'h555,8'hAA}, {W,4'd3,11'h2AA,8'h55}, {W,4'd3,11'h555,8'h20},
    {BYP,4'd3,11'h000,8'h01},
    // R4 bypass program
    {W,4'd4,11'h000,8'hA0}, {W,4'd4,11'h010,8'h5A}, {RDV,4'd4,11'h010,8'h5A},
    {W,4'd4,11'h7FF,8'hA0}, {W,4'd4,11'h011,8'h81}, {RDV,4'd4,11'h011,8'h81},
    // R5 other writes ignored in bypass
    {W,4'd5,11'h555,8'hAA}, {W,4'd5,11'h2AA,8'h55}, {W,4'd5,11'h555,8'h80},
    {W,4'd5,11'h555,8'hAA}, {W,4'd5,11'h2AA,8'h55}, {W,4'd5,11'h555,8'h10},
    {RDV,4'd5,11'h010,8'h5A},
    {W,4'd5,11'h012,8'h55}, {W,4'd5,11'h012,8'h00}, {RDV,4'd5,11'h012,8'hFF},
    // R6 bypass exit
    {W,4'd6,11'h0AB,8'h90}, {W,4'd6,11'h123,8'h01}, {BYP,4'd6,11'h000,8'h01},
    {RDV,4'd6,11'h123,8'h0C},
    {W,4'd6,11'h000,8'h90}, {W,4'd6,11'h004,8'h00}, {BYP,4'd6,11'h000,8'h00},
    {W,4'd6,11'h000,8'hA0}, {W,4'd6,11'h013,8'h00}, {RDV,4'd6,11'h013,8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accel_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic busy_o, err_o, bypass_o;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) dut (
    .clk(clk), .rst(rst), .accel_i(accel_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .err_o(err_o), .bypass_o(bypass_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy_o && guard < 10000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    wait_idle();
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic unlock_prog();
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h2AA, 8'h55);
    bus_wr(11'h555, 8'hA0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int busy_cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset busy", busy_o, 0);
    chk("R9 reset err", err_o, 0);
    chk("R9 reset bypass", bypass_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] rq;
      logic [10:0] a;
      logic [7:0] v;
      {op, rq, a, v} = VECS[i];
      case (op)
        W: bus_wr(a, v);
        RDV: begin
          bus_rd(a, rv);
          chk($sformatf("R%0d read vector %0d", rq, i), rv, v);
        end
        BYP: chk($sformatf("R%0d bypass vector %0d", rq, i), bypass_o, v[0]);
        default: chk($sformatf("R%0d error flag vector %0d", rq, i), err_o, v[0]);
      endcase
    end

    // R8 busy length and writes ignored while busy
    unlock_prog();
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 11'h400; wr_data_i = 8'h11;
    @(negedge clk);
    wr_en_i = 1'b0;
    busy_cnt = 0;
    while (busy_o && busy_cnt < 1000) begin
      busy_cnt++;
      wr_en_i = (busy_cnt <= 3);
      case (busy_cnt)
        1: begin wr_addr_i = 11'h555; wr_data_i = 8'hAA; end
        2: begin wr_addr_i = 11'h2AA; wr_data_i = 8'h55; end
        default: begin wr_addr_i = 11'h555; wr_data_i = 8'h20; end
      endcase
      @(negedge clk);
    end
    wr_en_i = 1'b0;
    chk("R8 busy cycles", busy_cnt, PROG_CYC + 1);
    chk("R8 writes while busy ignored", bypass_o, 0);
    bus_rd(11'h400, rv);
    chk("R8 programmed byte", rv, 8'h11);

    // R9 reset aborts a running program
    unlock_prog();
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 11'h401; wr_data_i = 8'h00;
    @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 busy after reset", busy_o, 0);
    chk("R9 bypass after reset", bypass_o, 0);
    bus_rd(11'h401, rv);
    chk("R9 aborted byte unchanged", rv, 8'hFF);
    bus_wr(11'h402, 8'h00);
    bus_rd(11'h402, rv);
    chk("R9 decoder idle after reset", rv, 8'hFF);

    // R11 accelerate input
    @(negedge clk);
    accel_i = 1'b1;
    @(negedge clk);
    chk("R11 accel enters bypass", bypass_o, 1);
    bus_wr(11'h000, 8'hA0);
    bus_wr(11'h500, 8'h77);
    bus_rd(11'h500, rv);
    chk("R11 accel bypass program", rv, 8'h77);
    bus_wr(11'h000, 8'h90);
    bus_wr(11'h000, 8'h00);
    @(negedge clk);
    chk("R11 exit blocked while accel", bypass_o, 1);
    accel_i = 1'b0;
    bus_wr(11'h000, 8'h90);
    bus_wr(11'h000, 8'h00);
    chk("R11 exit after accel release", bypass_o, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule